// File: doc/BRIEF.md
# Delay-Slot Branch Sequencer

This block owns the program counter of a small command-processing microcontroller. Every cycle in which the core steps, it takes the decoded control fields of the instruction at the current PC, plus the value of that instruction's source register, and works out the PC of the next instruction. It supports conditional branches on equality or inequality, unconditional jumps, and subroutine call and return. Instruction fetch, operand read and the ALU are outside the block.

Every control transfer has exactly one delay slot. The instruction that follows a taken branch, jump, call or return always executes, and only after that does the PC move to the target. Conditional branches have two forms. In the first, the source is compared with a 5-bit immediate. In the second, one bit of the source, picked by the same 5-bit field, is tested. Testing bit 1 of the ALU's three-valued compare code gives a less-than-or-equal branch, because that bit is set only in the codes for less-than (0x1e) and equal (0x2b), and clear in the code for greater-than (0x00). Relative targets are the sign-extended 16-bit offset added to the address of the control instruction. Calls nest through a small hardware return-address stack. There is no memory stack.

Top module: `brseq_top`

## Requirements
- R1: After reset, `pc` is 0, `inDelaySlot` is 0, `stackDepth` is 0 and `stackErr` is 0.
- R2: While `stepEn` is 0, no output changes, whatever the other inputs are. A step with `opCode` 0 (none) or any unused code 6–7 moves `pc` to `pc+1`.
- R3: A taken transfer at address A gives `pc` = A+1 with `inDelaySlot` = 1 after that step. The step after that gives the target with `inDelaySlot` = 0. A relative target is A plus the sign-extended `relOff`, modulo 2^PC_W.
- R4: Immediate form (`bitForm` = 0). `opCode` 1 (branch-if-equal) is taken when `srcVal` equals `immSel` zero-extended. `opCode` 2 (branch-if-not-equal) is taken when they differ. Every bit of `srcVal` takes part in the comparison.
- R5: Bit form (`bitForm` = 1). `immSel` is a bit index into `srcVal`. `opCode` 1 is taken when that bit is 1, and `opCode` 2 is taken when it is 0. With index 1 on a compare code, `opCode` 1 is taken for 0x1e and 0x2b and not taken for 0x00.
- R6: A branch that is not taken at A gives A+1 and then A+2, with `inDelaySlot` held at 0.
- R7: `opCode` 3 (jump) is always taken to the relative target, whatever `srcVal` is. Branch-if-equal on a zero source against immediate 0 acts the same way.
- R8: `opCode` 4 (call) at A is taken to the relative target and pushes A+2 (the address after its delay slot). `opCode` 5 (return) pops the newest entry and is taken to that address. Each changes `stackDepth` by one.
- R9: Up to 4 calls nest. Their returns come back in last-in, first-out order, and `stackErr` stays 0.
- R10: A call at depth 4 is still taken but saves nothing, and the depth stays at 4. A return at depth 0 is not taken. Both set `stackErr`, which stays set until reset.
- R11: Any control opcode stepped while `inDelaySlot` is 1 is ignored. The PC goes to the pending target, then to target+1, and `stackDepth` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepEn | input | 1 | The instruction at `pc` executes this cycle |
| opCode | input | 3 | 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 call, 5 return |
| bitForm | input | 1 | 1 selects the bit-test form for opcodes 1 and 2 |
| immSel | input | 5 | Compare immediate, or bit index in bit form |
| relOff | input | 16 | Signed offset relative to the control instruction |
| srcVal | input | 32 | Value of the source register |
| pc | output | 16 | Address of the instruction that executes next |
| inDelaySlot | output | 1 | The instruction at `pc` is a delay slot |
| stackDepth | output | 3 | Number of saved return addresses |
| stackErr | output | 1 | Sticky return-stack overflow or underflow |

## Verification
The bench targets the behaviour at the edges of the stack and the delay slot. If the return address saved by a call were taken from the call itself or from its slot, the return would land one or two instructions early. If a call made inside a delay slot were accepted, the depth would change and the PC would leave the pending target. If a design redirected at once, there would be no A+1 step. The branch table covers an immediate of 31 against a source with an upper bit set, which an equality check over only 5 bits gets wrong, and bit 31 and bit 1 on the three compare codes. A negative offset catches a zero-extended offset. The fifth call and the extra return check that the error flag is set and stays set, that the dropped entry leaves the older returns intact, and that a return with an empty stack falls through.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_BREQ = 3'd1,
    OP_BRNE = 3'd2,
    OP_JUMP = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } brOp_e;

  // Strobes from control to datapath for one step
  typedef struct packed {
    logic advance;   // a step happens this cycle
    logic redirect;  // leave the delay slot for the pending target
    logic latchTgt;  // capture a target, next step is a delay slot
    logic useRet;    // target comes from the top of the return stack
    logic push;      // save the return address
    logic pop;       // drop the newest return address
  } pcStrobe_t;

endpackage

// File: rtl/brseq_ctrl.sv
module brseq_ctrl
  import brseq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [2:0]        opCode,
  input  logic              bitForm,
  input  logic [IMM_W-1:0]  immSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic              stackFull,
  input  logic              stackEmpty,
  output pcStrobe_t         strb,
  output logic              inSlot,
  output logic              stackErr
);

  brOp_e op;
  logic  bitHit;
  logic  immHit;
  logic  condHit;
  logic  taken;
  logic  ctlStep;
  logic  badStack;

  always_comb begin
    op      = brOp_e'(opCode);
    bitHit  = srcVal[immSel];
    immHit  = (srcVal == DATA_W'(immSel));
    condHit = bitForm ? bitHit : immHit;
    unique case (op)
      OP_BREQ: taken = condHit;
      OP_BRNE: taken = !condHit;
      OP_JUMP: taken = 1'b1;
      OP_CALL: taken = 1'b1;
      OP_RET:  taken = !stackEmpty;
      default: taken = 1'b0;
    endcase
  end

  // Control opcodes count only outside a delay slot
  assign ctlStep  = stepEn && !inSlot;
  assign badStack = ((op == OP_CALL) && stackFull) || ((op == OP_RET) && stackEmpty);

  always_comb begin
    strb.advance  = stepEn;
    strb.redirect = stepEn && inSlot;
    strb.latchTgt = ctlStep && taken;
    strb.useRet   = (op == OP_RET);
    strb.push     = ctlStep && (op == OP_CALL) && !stackFull;
    strb.pop      = ctlStep && (op == OP_RET) && !stackEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSlot   <= 1'b0;
      stackErr <= 1'b0;
    end else begin
      if (stepEn) inSlot <= strb.latchTgt;
      if (ctlStep && badStack) stackErr <= 1'b1;
    end
  end

endmodule

// File: rtl/brseq_datapath.sv
module brseq_datapath
  import brseq_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int OFF_W    = 16,
  parameter int DEPTH    = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int PTR_W   = $clog2(DEPTH + 1),
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobe_t        strb,
  input  logic [OFF_W-1:0] relOff,
  output logic [PC_W-1:0]  pc,
  output logic [PTR_W-1:0] stackDepth,
  output logic             stackFull,
  output logic             stackEmpty
);

  logic [PC_W-1:0]  pcReg;
  logic [PC_W-1:0]  tgtReg;
  logic [PTR_W-1:0] spReg;
  logic [PC_W-1:0]  retStack [DEPTH];
  logic [PC_W-1:0]  relTgt;
  logic [PC_W-1:0]  retAddr;
  logic [PC_W-1:0]  topVal;
  logic [PTR_W-1:0] topPtr;

  assign relTgt     = pcReg + PC_W'($signed(relOff));
  assign retAddr    = pcReg + PC_W'(2);
  assign topPtr     = spReg - PTR_W'(1);
  assign topVal     = retStack[IDX_W'(topPtr)];
  assign stackFull  = (spReg == PTR_W'(DEPTH));
  assign stackEmpty = (spReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg  <= RESET_PC;
      tgtReg <= RESET_PC;
    end else if (strb.advance) begin
      pcReg <= strb.redirect ? tgtReg : pcReg + PC_W'(1);
      if (strb.latchTgt) tgtReg <= strb.useRet ? topVal : relTgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) spReg <= '0;
    else if (strb.push) spReg <= spReg + PTR_W'(1);
    else if (strb.pop) spReg <= topPtr;
  end

  // One register per stack entry, written when the pointer selects it
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) retStack[g] <= '0;
      else if (strb.push && (spReg == PTR_W'(g))) retStack[g] <= retAddr;
    end
  end

  assign pc         = pcReg;
  assign stackDepth = spReg;

endmodule

// File: rtl/brseq_top.sv
module brseq_top
  import brseq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 5,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepEn,
  input  logic [2:0]        opCode,
  input  logic              bitForm,
  input  logic [IMM_W-1:0]  immSel,
  input  logic [OFF_W-1:0]  relOff,
  input  logic [DATA_W-1:0] srcVal,
  output logic [PC_W-1:0]   pc,
  output logic              inDelaySlot,
  output logic [PTR_W-1:0]  stackDepth,
  output logic              stackErr
);

  pcStrobe_t strb;
  logic      stackFull;
  logic      stackEmpty;

  brseq_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .stepEn     (stepEn),
    .opCode     (opCode),
    .bitForm    (bitForm),
    .immSel     (immSel),
    .srcVal     (srcVal),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty),
    .strb       (strb),
    .inSlot     (inDelaySlot),
    .stackErr   (stackErr)
  );

  brseq_datapath #(.PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .relOff     (relOff),
    .pc         (pc),
    .stackDepth (stackDepth),
    .stackFull  (stackFull),
    .stackEmpty (stackEmpty)
  );

endmodule

// File: rtl/brseq_checker.sv
module brseq_checker #(
  parameter int PC_W  = 16,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepEn,
  input logic [2:0]       opCode,
  input logic [PC_W-1:0]  pc,
  input logic             inDelaySlot,
  input logic [PTR_W-1:0] stackDepth,
  input logic             stackErr
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stepEn |=> $stable(pc) && $stable(inDelaySlot) && $stable(stackDepth));

  p_seq_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !inDelaySlot && opCode == 3'd0) |=> (pc == $past(pc) + PC_W'(1)) && !inDelaySlot);

  p_jump_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !inDelaySlot && opCode == 3'd3) |=> inDelaySlot && (pc == $past(pc) + PC_W'(1)));

  p_call_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !inDelaySlot && opCode == 3'd4 && stackDepth < PTR_W'(DEPTH))
      |=> stackDepth == $past(stackDepth) + PTR_W'(1));

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= PTR_W'(DEPTH));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

  p_slot_ignore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && inDelaySlot) |=> !inDelaySlot && $stable(stackDepth) && $stable(stackErr));

endmodule

bind brseq_top brseq_checker #(.PC_W(PC_W), .DEPTH(DEPTH)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .stepEn      (stepEn),
  .opCode      (opCode),
  .pc          (pc),
  .inDelaySlot (inDelaySlot),
  .stackDepth  (stackDepth),
  .stackErr    (stackErr)
);

// File: tb/brseq_top_tb_top.sv
module brseq_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        bitForm = 1'b0;
  logic [4:0]  immSel = 5'd0;
  logic [15:0] relOff = 16'd0;
  logic [31:0] srcVal = 32'd0;
  logic [15:0] pc;
  logic        inDelaySlot;
  logic [2:0]  stackDepth;
  logic        stackErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brseq_top dut_i (
    .clk(clk), .rstN(rstN), .stepEn(stepEn), .opCode(opCode), .bitForm(bitForm),
    .immSel(immSel), .relOff(relOff), .srcVal(srcVal), .pc(pc),
    .inDelaySlot(inDelaySlot), .stackDepth(stackDepth), .stackErr(stackErr)
  );

  // {op[3], bitForm, imm[5], src[32], taken}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {3'd1, 1'b0, 5'd5,  32'h0000_0005, 1'b1},  // R4 eq hit
    {3'd1, 1'b0, 5'd5,  32'h0000_0006, 1'b0},  // R4 eq miss
    {3'd2, 1'b0, 5'd5,  32'h0000_0006, 1'b1},  // R4 ne hit
    {3'd2, 1'b0, 5'd0,  32'h0000_0000, 1'b0},  // R4 ne miss
    {3'd1, 1'b0, 5'd31, 32'h0000_001F, 1'b1},  // R4 max imm
    {3'd1, 1'b0, 5'd31, 32'h0000_011F, 1'b0},  // R4 upper bits count
    {3'd1, 1'b1, 5'd3,  32'h0000_0008, 1'b1},  // R5 bit set
    {3'd2, 1'b1, 5'd3,  32'h0000_0008, 1'b0},  // R5 bit set, ne
    {3'd1, 1'b1, 5'd1,  32'h0000_001E, 1'b1},  // R5 less-than code
    {3'd1, 1'b1, 5'd1,  32'h0000_002B, 1'b1},  // R5 equal code
    {3'd1, 1'b1, 5'd1,  32'h0000_0000, 1'b0},  // R5 greater code
    {3'd1, 1'b0, 5'd0,  32'h0000_0000, 1'b1},  // R7 zero reg
    {3'd3, 1'b0, 5'd9,  32'h1234_5678, 1'b1},  // R7 jump
    {3'd2, 1'b1, 5'd31, 32'h7FFF_FFFF, 1'b1}   // R5 top bit clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStep(input logic [2:0] op, input logic bf, input logic [4:0] imm,
                        input logic [15:0] off, input logic [31:0] src);
    @(negedge clk);
    opCode = op; bitForm = bf; immSel = imm; relOff = off; srcVal = src; stepEn = 1'b1;
    @(posedge clk);
    #1;
    stepEn = 1'b0; opCode = 3'd0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; stepEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] a;
    logic [15:0] saved [4];

    doReset();
    check("R1 pc", 32'(pc), 0);
    check("R1 slot", 32'(inDelaySlot), 0);
    check("R1 depth", 32'(stackDepth), 0);
    check("R1 err", 32'(stackErr), 0);

    // R2: inputs change but no step
    @(negedge clk);
    opCode = 3'd4; relOff = 16'h0040; srcVal = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #1;
    check("R2 hold pc", 32'(pc), 0);
    check("R2 hold depth", 32'(stackDepth), 0);
    opCode = 3'd0;
    doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R2 seq", 32'(pc), 1);
    doStep(3'd7, 1'b0, 5'd0, 16'h0040, 32'd0);
    check("R2 unused opcode", 32'(pc), 2);

    // Table of branch conditions (R3, R4, R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      logic taken;
      taken = VEC[i][0];
      a = pc;
      doStep(VEC[i][41:39], VEC[i][38], VEC[i][37:33], 16'h0010, VEC[i][32:1]);
      check($sformatf("R3/R6 vec%0d slot pc", i), 32'(pc), 32'(a + 16'd1));
      check($sformatf("R4/R5 vec%0d slot flag", i), 32'(inDelaySlot), 32'(taken));
      doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
      check($sformatf("R3/R6 vec%0d next pc", i), 32'(pc), 32'(taken ? a + 16'h0010 : a + 16'd2));
    end

    // R3 negative offset
    a = pc;
    doStep(3'd3, 1'b0, 5'd0, 16'hFFFC, 32'd0);
    doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R3 negative offset", 32'(pc), 32'(a - 16'd4));

    // R11: control op in delay slot is ignored
    a = pc;
    doStep(3'd3, 1'b0, 5'd0, 16'h0008, 32'd0);
    doStep(3'd4, 1'b0, 5'd0, 16'h0040, 32'd0);
    check("R11 pending target", 32'(pc), 32'(a + 16'd8));
    check("R11 depth", 32'(stackDepth), 0);
    doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R11 no second redirect", 32'(pc), 32'(a + 16'd9));

    // R8 and R9: four nested calls
    for (int k = 0; k < 4; k++) begin
      a = pc;
      saved[k] = a + 16'd2;
      doStep(3'd4, 1'b0, 5'd0, 16'h0020, 32'd0);
      check("R8 call depth", 32'(stackDepth), 32'(k + 1));
      doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
      check("R8 call target", 32'(pc), 32'(a + 16'h0020));
    end
    check("R9 no error at depth 4", 32'(stackErr), 0);

    // R10 overflow: still taken, nothing saved
    a = pc;
    doStep(3'd4, 1'b0, 5'd0, 16'h0020, 32'd0);
    check("R10 overflow depth", 32'(stackDepth), 4);
    check("R10 overflow err", 32'(stackErr), 1);
    doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R10 overflow target", 32'(pc), 32'(a + 16'h0020));

    // R9: returns come back LIFO
    for (int k = 3; k >= 0; k--) begin
      doStep(3'd5, 1'b0, 5'd0, 16'h0000, 32'd0);
      check("R8 ret slot", 32'(inDelaySlot), 1);
      doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
      check("R9 ret address", 32'(pc), 32'(saved[k]));
      check("R9 ret depth", 32'(stackDepth), 32'(k));
    end

    // R10 underflow: return not taken
    a = pc;
    doStep(3'd5, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R10 underflow no slot", 32'(inDelaySlot), 0);
    check("R10 underflow pc", 32'(pc), 32'(a + 16'd1));
    check("R10 sticky err", 32'(stackErr), 1);
    doStep(3'd0, 1'b0, 5'd0, 16'h0000, 32'd0);
    check("R10 err still set", 32'(stackErr), 1);

    doReset();
    check("R1 reset clears err", 32'(stackErr), 0);
    check("R1 reset pc", 32'(pc), 0);

    finishRun();
  end

endmodule